// File: doc/BRIEF.md
# Delayed Read Completion Matcher

This block sits on the target side of a bridge that answers inbound memory reads as delayed transactions. It holds a small table of delayed reads that were accepted earlier. For each one it keeps the address, the read command, and whether its completion data has arrived yet. When a new read request arrives, the block compares it with the table and gives one registered verdict a cycle later. There are four possible verdicts:

- The stored completion is ready: the data can be returned, and the entry is retired.
- The completion is still pending: the requester must retry.
- There is no match and the table has room: a new delayed read is enqueued.
- There is no match and the table is full: the requester must retry, and nothing is allocated.

A control input selects whether the three memory read commands count as interchangeable during matching. When they do, only the address has to agree. The data path outside the block raises one flag per entry when that entry's completion data is in place. The block stores no data and moves none.

Top module: `drm_matcher`

## Requirements
- R1: A synchronous active-high reset empties the table and clears every output. The first read request after reset is therefore a miss that allocates index 0.
- R2: Only command codes 4'b0110, 4'b1110 and 4'b1100 are read commands. Any other code gets a response with hit, retire, enq and retry all low and rsp_idx 0, and it leaves the table unchanged.
- R3: With alias_en low, a stored entry matches only when both its address and its command equal the request's. An entry that agrees on address alone is treated as a miss.
- R4: With alias_en high, any valid entry whose address equals the request's matches, whichever of the three read commands either side carries.
- R5: A match on an entry whose completion is ready raises rsp_hit and rsp_retire with rsp_idx set to that entry, and frees the entry.
- R6: A match on an entry whose completion is not ready raises rsp_retry with rsp_hit low and rsp_idx set to that entry. The entry is kept.
- R7: A miss while the table has a free entry raises rsp_enq with rsp_idx set to the lowest free index. That entry then holds the request's address and command, marked not ready.
- R8: A miss while all entries are in use raises rsp_retry with rsp_idx 0, and nothing is allocated.
- R9: A pulse on cpl_rdy[i] marks entry i ready only if that entry is valid; on a free entry the pulse is ignored. A request in the same cycle as the pulse is judged on the state before the pulse.
- R10: Each request produces exactly one response, with rsp_valid high in the cycle after the request. When rsp_valid is low, all other outputs are low.
- R11: When several entries match, the lowest index is chosen.
- R12: At most one of rsp_hit, rsp_enq and rsp_retry is high, and rsp_retire equals rsp_hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | AW | Request address |
| req_cmd | input | 4 | Request command code |
| alias_en | input | 1 | Treat the three read commands as equal for matching |
| cpl_rdy | input | N_ENT | Per-entry completion-arrived pulses from the data path |
| rsp_valid | output | 1 | Verdict for the previous cycle's request |
| rsp_hit | output | 1 | Ready completion found; data may be returned |
| rsp_retire | output | 1 | The matched entry has been freed |
| rsp_enq | output | 1 | New delayed read allocated |
| rsp_retry | output | 1 | Requester must retry |
| rsp_idx | output | IW | Entry the verdict refers to |

## Verification
Two functions can fall in the same cycle: a completion-ready pulse from the data path, and a request that matches the same entry. The bench provokes this by asserting cpl_rdy for an entry together with a read to that entry's address. The expected verdict is a retry, because the pulse is not yet visible. A repeat of the same read in the next cycle must then hit and retire.

The bench also checks that a pulse aimed at a free entry leaves no trace: that entry is allocated afterwards, and a matching read must still be told to retry.

// File: rtl/drm_pkg.sv
package drm_pkg;
  localparam logic [3:0] CMD_MRD  = 4'b0110;
  localparam logic [3:0] CMD_MRDL = 4'b1110;
  localparam logic [3:0] CMD_MRDM = 4'b1100;

  function automatic logic is_mem_read(input logic [3:0] cmd);
    return (cmd == CMD_MRD) || (cmd == CMD_MRDL) || (cmd == CMD_MRDM);
  endfunction
endpackage

// File: rtl/drm_lowest.sv
module drm_lowest #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/drm_table.sv
module drm_table #(
  parameter int N_ENT = 4,
  parameter int AW    = 32,
  parameter int IW    = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      alloc_en,
  input  logic [IW-1:0]             alloc_idx,
  input  logic [AW-1:0]             alloc_addr,
  input  logic [3:0]                alloc_cmd,
  input  logic                      retire_en,
  input  logic [IW-1:0]             retire_idx,
  input  logic [N_ENT-1:0]          rdy_set,
  output logic [N_ENT-1:0]          ent_valid,
  output logic [N_ENT-1:0]          ent_rdy,
  output logic [N_ENT-1:0][AW-1:0]  ent_addr,
  output logic [N_ENT-1:0][3:0]     ent_cmd
);
  logic [AW-1:0] addr_mem [N_ENT];
  logic [3:0]    cmd_mem  [N_ENT];

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      addr_mem[alloc_idx] <= alloc_addr;
      cmd_mem[alloc_idx]  <= alloc_cmd;
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_valid[g] <= 1'b0;
        ent_rdy[g]   <= 1'b0;
      end else if (alloc_en && alloc_idx == IW'(g)) begin
        ent_valid[g] <= 1'b1;
        ent_rdy[g]   <= 1'b0;
      end else if (retire_en && retire_idx == IW'(g)) begin
        ent_valid[g] <= 1'b0;
        ent_rdy[g]   <= 1'b0;
      end else if (rdy_set[g] && ent_valid[g]) begin
        ent_rdy[g]   <= 1'b1;
      end
    end
    assign ent_addr[g] = addr_mem[g];
    assign ent_cmd[g]  = cmd_mem[g];
  end
endmodule

// File: rtl/drm_compare.sv
module drm_compare #(
  parameter int N_ENT = 4,
  parameter int AW    = 32
) (
  input  logic [AW-1:0]             req_addr,
  input  logic [3:0]                req_cmd,
  input  logic                      alias_en,
  input  logic [N_ENT-1:0]          ent_valid,
  input  logic [N_ENT-1:0][AW-1:0]  ent_addr,
  input  logic [N_ENT-1:0][3:0]     ent_cmd,
  output logic [N_ENT-1:0]          match
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    logic addr_eq, cmd_eq;
    assign addr_eq  = (ent_addr[g] == req_addr);
    assign cmd_eq   = (ent_cmd[g] == req_cmd);
    assign match[g] = ent_valid[g] && addr_eq && (alias_en || cmd_eq);
  end
endmodule

// File: rtl/drm_matcher.sv
module drm_matcher #(
  parameter int N_ENT = 4,
  parameter int AW    = 32,
  localparam int IW   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic [3:0]       req_cmd,
  input  logic             alias_en,
  input  logic [N_ENT-1:0] cpl_rdy,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_retire,
  output logic             rsp_enq,
  output logic             rsp_retry,
  output logic [IW-1:0]    rsp_idx
);
  logic [N_ENT-1:0]         ent_valid, ent_rdy, match;
  logic [N_ENT-1:0][AW-1:0] ent_addr;
  logic [N_ENT-1:0][3:0]    ent_cmd;
  logic                     hit_any, free_any;
  logic [IW-1:0]            hit_idx, free_idx;
  logic                     is_rd, do_retire, do_wait, do_alloc, do_full;

  assign is_rd = req_valid && drm_pkg::is_mem_read(req_cmd);

  drm_compare #(.N_ENT(N_ENT), .AW(AW)) u_cmp (
    .req_addr (req_addr),
    .req_cmd  (req_cmd),
    .alias_en (alias_en),
    .ent_valid(ent_valid),
    .ent_addr (ent_addr),
    .ent_cmd  (ent_cmd),
    .match    (match)
  );

  drm_lowest #(.N(N_ENT), .IW(IW)) u_hit_pick (
    .vec  (match),
    .found(hit_any),
    .idx  (hit_idx)
  );

  drm_lowest #(.N(N_ENT), .IW(IW)) u_free_pick (
    .vec  (~ent_valid),
    .found(free_any),
    .idx  (free_idx)
  );

  assign do_retire = is_rd && hit_any && ent_rdy[hit_idx];
  assign do_wait   = is_rd && hit_any && !ent_rdy[hit_idx];
  assign do_alloc  = is_rd && !hit_any && free_any;
  assign do_full   = is_rd && !hit_any && !free_any;

  drm_table #(.N_ENT(N_ENT), .AW(AW), .IW(IW)) u_tbl (
    .clk       (clk),
    .rst       (rst),
    .alloc_en  (do_alloc),
    .alloc_idx (free_idx),
    .alloc_addr(req_addr),
    .alloc_cmd (req_cmd),
    .retire_en (do_retire),
    .retire_idx(hit_idx),
    .rdy_set   (cpl_rdy),
    .ent_valid (ent_valid),
    .ent_rdy   (ent_rdy),
    .ent_addr  (ent_addr),
    .ent_cmd   (ent_cmd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_retire <= 1'b0;
      rsp_enq    <= 1'b0;
      rsp_retry  <= 1'b0;
      rsp_idx    <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= do_retire;
      rsp_retire <= do_retire;
      rsp_enq    <= do_alloc;
      rsp_retry  <= do_wait || do_full;
      if (do_retire || do_wait) rsp_idx <= hit_idx;
      else if (do_alloc)        rsp_idx <= free_idx;
      else                      rsp_idx <= '0;
    end
  end
endmodule

// File: rtl/drm_matcher_chk.sv
module drm_matcher_chk #(
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [3:0]    req_cmd,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic          rsp_retire,
  input logic          rsp_enq,
  input logic          rsp_retry,
  input logic [IW-1:0] rsp_idx
);
  // R12
  verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_hit, rsp_enq, rsp_retry}));

  // R12
  retire_eq_hit_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_retire == rsp_hit);

  // R10
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R10
  no_rsp_wo_req_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R10
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_enq || rsp_retry || rsp_retire) && rsp_idx == '0);

  // R2
  nonread_inert_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !drm_pkg::is_mem_read(req_cmd) |=>
      !(rsp_hit || rsp_enq || rsp_retry) && rsp_idx == '0);
endmodule

bind drm_matcher drm_matcher_chk #(.IW(IW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_cmd   (req_cmd),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_retire(rsp_retire),
  .rsp_enq   (rsp_enq),
  .rsp_retry (rsp_retry),
  .rsp_idx   (rsp_idx)
);

// File: tb/drm_matcher_tb.sv
module drm_matcher_tb;
  localparam int N  = 4;
  localparam int AW = 32;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_cmd = '0;
  logic alias_en = 1'b0;
  logic [N-1:0] cpl_rdy = '0;
  logic rsp_valid, rsp_hit, rsp_retire, rsp_enq, rsp_retry;
  logic [IW-1:0] rsp_idx;

  always #4 clk = ~clk;

  drm_matcher #(.N_ENT(N), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_cmd(req_cmd), .alias_en(alias_en), .cpl_rdy(cpl_rdy),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_retire(rsp_retire),
    .rsp_enq(rsp_enq), .rsp_retry(rsp_retry), .rsp_idx(rsp_idx)
  );

  typedef struct {
    bit hit, ret, enq, rty;
    int idx;
    string tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit m_v[N];
  bit m_r[N];
  logic [AW-1:0] m_a[N];
  logic [3:0] m_c[N];

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R10: response with nothing expected (hit=%0b enq=%0b retry=%0b)",
                 rsp_hit, rsp_enq, rsp_retry);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rsp_hit !== e.hit || rsp_retire !== e.ret || rsp_enq !== e.enq ||
            rsp_retry !== e.rty || int'(rsp_idx) != e.idx) begin
          errors++;
          $display("FAIL %s: got hit=%0b ret=%0b enq=%0b retry=%0b idx=%0d, expected hit=%0b ret=%0b enq=%0b retry=%0b idx=%0d",
                   e.tag, rsp_hit, rsp_retire, rsp_enq, rsp_retry, rsp_idx,
                   e.hit, e.ret, e.enq, e.rty, e.idx);
        end
      end
    end
  end

  function automatic bit is_rd(input logic [3:0] c);
    return c == 4'b0110 || c == 4'b1110 || c == 4'b1100;
  endfunction

  task automatic apply_rdy(input logic [N-1:0] rdy, input bit vold[N], input int skip);
    for (int i = 0; i < N; i++)
      if (rdy[i] && vold[i] && i != skip) m_r[i] = 1'b1;
  endtask

  task automatic drive(input logic [AW-1:0] a, input logic [3:0] c, input bit al,
                       input logic [N-1:0] rdy, input string tag);
    exp_t e;
    bit vold[N];
    int h, f, touched;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_cmd = c; alias_en = al; cpl_rdy = rdy;
    vold = m_v;
    h = -1; f = -1; touched = -1;
    for (int i = 0; i < N; i++) begin
      if (h < 0 && m_v[i] && m_a[i] == a && (al || m_c[i] == c)) h = i;
      if (f < 0 && !m_v[i]) f = i;
    end
    e.hit = 0; e.ret = 0; e.enq = 0; e.rty = 0; e.idx = 0; e.tag = tag;
    if (is_rd(c)) begin
      if (h >= 0) begin
        e.idx = h;
        if (m_r[h]) begin
          e.hit = 1; e.ret = 1; m_v[h] = 0; m_r[h] = 0; touched = h;
        end else e.rty = 1;
      end else if (f >= 0) begin
        e.enq = 1; e.idx = f;
        m_v[f] = 1; m_r[f] = 0; m_a[f] = a; m_c[f] = c; touched = f;
      end else e.rty = 1;
    end
    apply_rdy(rdy, vold, touched);
    sb.push_back(e);
  endtask

  task automatic idle(input logic [N-1:0] rdy);
    bit vold[N];
    @(negedge clk);
    req_valid = 1'b0; cpl_rdy = rdy;
    vold = m_v;
    apply_rdy(rdy, vold, -1);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_r[i] = 0; m_a[i] = '0; m_c[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_enq !== 1'b0 || rsp_retry !== 1'b0) begin
      errors++;
      $display("FAIL R1: outputs after reset valid=%0b hit=%0b enq=%0b retry=%0b, expected all 0",
               rsp_valid, rsp_hit, rsp_enq, rsp_retry);
    end
    drive(32'h100, 4'b1100, 0, '0, "R1 R7 first alloc");
    drive(32'h100, 4'b1100, 0, '0, "R6 pending retry");
    idle(4'b0001);
    drive(32'h100, 4'b0110, 0, '0, "R3 addr-only miss");
    drive(32'h100, 4'b0110, 1, '0, "R4 R11 alias lowest ready");
    drive(32'h100, 4'b0110, 0, '0, "R6 entry1 pending");
    drive(32'h200, 4'b0111, 0, '0, "R2 non-read inert");
    drive(32'h200, 4'b0110, 0, '0, "R2 R7 table untouched by non-read");
    drive(32'h200, 4'b0110, 0, 4'b0001, "R9 same-cycle pulse not seen");
    drive(32'h200, 4'b0110, 0, '0, "R5 R9 hit after pulse");
    drive(32'h300, 4'b1110, 0, '0, "R7 alloc idx0");
    drive(32'h400, 4'b0110, 0, '0, "R7 alloc idx2");
    drive(32'h500, 4'b0110, 0, '0, "R7 alloc idx3");
    drive(32'h600, 4'b0110, 0, '0, "R8 full retry");
    idle(4'b1111);
    drive(32'h300, 4'b1110, 0, '0, "R5 retire idx0");
    idle(4'b0001);
    drive(32'h700, 4'b0110, 0, '0, "R7 realloc idx0");
    drive(32'h700, 4'b0110, 0, '0, "R9 pulse on free entry ignored");
    drive(32'h400, 4'b1100, 1, '0, "R4 alias cross command");
    drive(32'h500, 4'b1110, 0, '0, "R3 command differs");
    drive(32'h600, 4'b0110, 0, '0, "R8 no alloc while full");
    drive(32'h500, 4'b0110, 0, '0, "R5 exact match ready");
    drive(32'h600, 4'b0110, 0, '0, "R7 alloc after free");
    idle('0);
    idle('0);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R10: %0d responses missing, expected 0", sb.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule